// File: doc/BRIEF.md
# Symmetric Decimating Channel FIR

This block is the last filter of a receive channel. It runs a 63-tap linear-phase FIR over a stream of signed samples and produces one filtered sample for every two or every four accepted inputs. Since the impulse response is even-symmetric, only 32 distinct coefficient words are held. Word 31 weights the centre tap, and each word k below 31 weights the pair of taps k and 62-k. The two samples that share a word are added before the multiply, so one multiplier is enough for the whole filter.

Each output takes 32 clocks. A single pre-adder and multiply-accumulate stage walks the 32 coefficient words, and the accumulator is wide enough to hold the full sum. The sum is then rounded and clipped back to the sample width. Coefficients come from one of two sets: a built-in set computed in logic, or a 32-word user bank that the host loads through a write port. A small mode register selects the decimation factor and the coefficient set. Whenever the factor is 4 the user bank is used, whatever the set-select bit says. The filter expects at least 32 clocks between output-triggering inputs. In practice this means at least 16 clocks between inputs at factor 2 and at least 8 at factor 4.

Top module: `symfir_decim`

## Requirements
- R1: After reset, out_valid is low, out_data is 0, every stored sample reads as zero, the factor is 2 and the built-in set is selected.
- R2: Each output is the sum over j = 0..62 of h[j]·x[n-j], where x[n] is the sample that triggered the output, x before reset counts as 0, and h[j] = word[j] for j ≤ 31 and word[62-j] for j > 31.
- R3: With mode_dec4 = 0 latched, an output is produced on the 2nd, 4th, 6th, … accepted input counted from reset or from the last accepted mode write.
- R4: With mode_dec4 = 1 latched, an output is produced on every 4th accepted input, and the user bank is used even when mode_user = 0.
- R5: The built-in set has word k equal to 256·(k+1), for k = 0..31.
- R6: A coefficient write (coef_we high) stores coef_data into user word coef_addr. It is accepted whenever no output is being computed, including while rst_n is low, and the user bank keeps its contents through reset.
- R7: A coefficient write issued while an output is being computed has no effect.
- R8: out_valid is a one-cycle pulse that rises on the 32nd rising edge after the edge that accepted the triggering input, and it never rises at any other time.
- R9: The full-precision sum S is reduced to floor((S + 2^14) / 2^15) and then clipped to the range -32768..32767.
- R10: A mode write (mode_we high) latches mode_dec4 and mode_user and restarts the input count. It is accepted only while no output is being computed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| coef_we | input | 1 | User coefficient write strobe |
| coef_addr | input | 5 | User coefficient word index (31 = centre tap) |
| coef_data | input | 16 | Signed coefficient, 15 fractional bits |
| mode_we | input | 1 | Mode register write strobe |
| mode_dec4 | input | 1 | 1 = decimate by 4, 0 = decimate by 2 |
| mode_user | input | 1 | 1 = user bank, 0 = built-in set (ignored at factor 4) |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Rounded, saturated filtered sample |

## Verification
A wrong ring pointer or a bad mirrored-index calculation leaves the output timing intact, but it corrupts the value of the very next output, because every output reads all 63 stored samples. A phase counter that miscounts, or a mode change that slips through, shows up as outputs at the wrong input positions. That error is caught on the first output after the fault, and again by the total number of pulses at the end. A coefficient write that leaks in while a computation is running changes the values of later outputs against the arithmetic model. The run-length check catches a stuck or early-ending computation within one output period.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    typedef enum logic {
        DEC_BY2 = 1'b0,
        DEC_BY4 = 1'b1
    } dec_e;

    // Built-in coefficient word k: a rising ramp of 256*(k+1)
    function automatic int builtin_word(input int k);
        return 256 * (k + 1);
    endfunction

endpackage

// File: rtl/symfir_coef_bank.sv
module symfir_coef_bank
    import symfir_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int NUNIQ  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    input  logic                     use_user,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [COEF_W-1:0] rd_coef
);

    // User words: no reset, so that loads made while reset is held survive it
    logic [NUNIQ-1:0][COEF_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (int'(wr_addr) < NUNIQ)) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    always_comb begin
        if (use_user) begin
            rd_coef = mem_q[rd_addr];
        end else begin
            rd_coef = COEF_W'(builtin_word(int'(rd_addr)));
        end
    end

endmodule

// File: rtl/symfir_ring.sv
module symfir_ring #(
    parameter int DATA_W = 16,
    parameter int NTAPS  = 63,
    parameter int IDX_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic signed [DATA_W-1:0] wr_data,
    output logic [IDX_W-1:0]         wr_idx,
    input  logic [IDX_W-1:0]         rd_a_idx,
    input  logic [IDX_W-1:0]         rd_b_idx,
    output logic signed [DATA_W-1:0] rd_a,
    output logic signed [DATA_W-1:0] rd_b
);

    logic signed [DATA_W-1:0] mem_d [NTAPS];
    logic signed [DATA_W-1:0] mem_q [NTAPS];
    logic [IDX_W-1:0]         wp_d, wp_q;

    always_comb begin
        mem_d = mem_q;
        wp_d  = wp_q;
        if (wr_en) begin
            mem_d[wp_q] = wr_data;
            wp_d        = (wp_q == IDX_W'(NTAPS - 1)) ? '0 : wp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAPS; i++) begin
                mem_q[i] <= '0;
            end
            wp_q <= '0;
        end else begin
            mem_q <= mem_d;
            wp_q  <= wp_d;
        end
    end

    assign wr_idx = wp_q;
    assign rd_a   = mem_q[rd_a_idx];
    assign rd_b   = mem_q[rd_b_idx];

endmodule

// File: rtl/symfir_mac.sv
module symfir_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 38
) (
    input  logic signed [DATA_W-1:0] tap_a,
    input  logic signed [DATA_W-1:0] tap_b,
    input  logic                     pair_en,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [ACC_W-1:0]  acc_in,
    output logic signed [ACC_W-1:0]  acc_out,
    output logic signed [DATA_W-1:0] y_out
);

    localparam int SUM_W  = DATA_W + 1;
    localparam int PROD_W = SUM_W + COEF_W;
    localparam int FRAC   = COEF_W - 1;
    localparam logic signed [ACC_W-1:0] YMAX = ACC_W'((longint'(1) <<< (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] YMIN = -YMAX - 1;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(longint'(1) <<< (FRAC - 1));

    logic signed [SUM_W-1:0]  pre;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  rnd, scaled;

    always_comb begin
        pre     = SUM_W'(tap_a) + (pair_en ? SUM_W'(tap_b) : SUM_W'(0));
        prod    = PROD_W'(pre) * PROD_W'(coef);
        acc_out = acc_in + ACC_W'(prod);
        rnd     = acc_out + HALF;
        scaled  = rnd >>> FRAC;
        if (scaled > YMAX) begin
            y_out = DATA_W'(YMAX);
        end else if (scaled < YMIN) begin
            y_out = DATA_W'(YMIN);
        end else begin
            y_out = DATA_W'(scaled);
        end
    end

endmodule

// File: rtl/symfir_decim.sv
module symfir_decim
    import symfir_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 63
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     coef_we,
    input  logic [$clog2((NTAPS+1)/2)-1:0] coef_addr,
    input  logic signed [COEF_W-1:0] coef_data,
    input  logic                     mode_we,
    input  logic                     mode_dec4,
    input  logic                     mode_user,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int NUNIQ  = (NTAPS + 1) / 2;
    localparam int ADDR_W = $clog2(NUNIQ);
    localparam int IDX_W  = $clog2(NTAPS);
    localparam int ACC_W  = DATA_W + COEF_W + 1 + $clog2(NUNIQ);

    typedef struct packed {
        logic                     busy;
        logic [ADDR_W-1:0]        k;
        logic [IDX_W-1:0]         base;
        logic [1:0]               phase;
        dec_e                     dec;
        logic                     user;
        logic                     run_user;
        logic signed [ACC_W-1:0]  acc;
        logic                     ovalid;
        logic signed [DATA_W-1:0] odata;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0]         wr_idx, a_idx, b_idx;
    logic signed [DATA_W-1:0] tap_a, tap_b, y_sat;
    logic signed [COEF_W-1:0] coef;
    logic signed [ACC_W-1:0]  acc_next;
    logic                     pair_en;

    // Mirror addressing: newest-k and newest-(62-k), both modulo the ring size
    always_comb begin
        int ia, ib;
        ia = int'(st_q.base) - int'(st_q.k);
        if (ia < 0) ia = ia + NTAPS;
        ib = int'(st_q.base) + 1 + int'(st_q.k);
        if (ib >= NTAPS) ib = ib - NTAPS;
        a_idx   = IDX_W'(ia);
        b_idx   = IDX_W'(ib);
        pair_en = (st_q.k != ADDR_W'(NUNIQ - 1));
    end

    symfir_ring #(.DATA_W(DATA_W), .NTAPS(NTAPS), .IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_data(in_data),
        .wr_idx(wr_idx), .rd_a_idx(a_idx), .rd_b_idx(b_idx),
        .rd_a(tap_a), .rd_b(tap_b)
    );

    symfir_coef_bank #(.COEF_W(COEF_W), .NUNIQ(NUNIQ), .ADDR_W(ADDR_W)) u_coef (
        .clk(clk), .wr_en(coef_we && !st_q.busy), .wr_addr(coef_addr),
        .wr_data(coef_data), .use_user(st_q.run_user), .rd_addr(st_q.k),
        .rd_coef(coef)
    );

    symfir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
        .tap_a(tap_a), .tap_b(tap_b), .pair_en(pair_en), .coef(coef),
        .acc_in(st_q.acc), .acc_out(acc_next), .y_out(y_sat)
    );

    always_comb begin
        logic [1:0] last_phase;
        st_d        = st_q;
        st_d.ovalid = 1'b0;
        last_phase  = (st_q.dec == DEC_BY4) ? 2'd3 : 2'd1;

        if (st_q.busy) begin
            st_d.acc = acc_next;
            st_d.k   = st_q.k + 1'b1;
            if (st_q.k == ADDR_W'(NUNIQ - 1)) begin
                st_d.busy   = 1'b0;
                st_d.ovalid = 1'b1;
                st_d.odata  = y_sat;
            end
        end

        if (mode_we && !st_q.busy) begin
            st_d.dec   = mode_dec4 ? DEC_BY4 : DEC_BY2;
            st_d.user  = mode_user;
            st_d.phase = '0;
        end else if (in_valid) begin
            if (st_q.phase == last_phase) begin
                st_d.phase = '0;
                if (!st_q.busy) begin
                    st_d.busy     = 1'b1;
                    st_d.k        = '0;
                    st_d.base     = wr_idx;
                    st_d.acc      = '0;
                    st_d.run_user = st_q.user || (st_q.dec == DEC_BY4);
                end
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, k: '0, base: '0, phase: '0, dec: DEC_BY2,
                      user: 1'b0, run_user: 1'b0, acc: '0, ovalid: 1'b0,
                      odata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ovalid;
    assign out_data  = st_q.odata;

endmodule

// File: rtl/symfir_decim_chk.sv
module symfir_decim_chk #(
    parameter int K_W    = 5,
    parameter int LAST_K = 31,
    parameter int MEM_W  = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [K_W-1:0]   k,
    input logic             out_valid,
    input logic             coef_we,
    input logic             mode_we,
    input logic             dec4,
    input logic [MEM_W-1:0] user_mem
);

    // R8
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (k != K_W'(LAST_K)) |=> busy);

    // R8
    out_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (k == K_W'(LAST_K)) |=> out_valid && !busy);

    // R8
    out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(busy));

    // R7
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && coef_we |=> $stable(user_mem));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mode_we |=> $stable(dec4));

endmodule

bind symfir_decim symfir_decim_chk #(
    .K_W(ADDR_W), .LAST_K(NUNIQ - 1), .MEM_W(NUNIQ * COEF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(st_q.busy), .k(st_q.k),
    .out_valid(out_valid), .coef_we(coef_we), .mode_we(mode_we),
    .dec4(st_q.dec == symfir_pkg::DEC_BY4), .user_mem(u_coef.mem_q)
);

// File: tb/symfir_decim_test.sv
`timescale 1ns/1ps
module symfir_decim_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic              coef_we = 1'b0;
    logic [4:0]        coef_addr = '0;
    logic signed [15:0] coef_data = '0;
    logic              mode_we = 1'b0;
    logic              mode_dec4 = 1'b0;
    logic              mode_user = 1'b0;
    logic              out_valid;
    logic signed [15:0] out_data;

    always #2.5 clk = ~clk;

    symfir_decim uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .mode_we(mode_we), .mode_dec4(mode_dec4), .mode_user(mode_user),
        .out_valid(out_valid), .out_data(out_data)
    );

    int  checks = 0, fails = 0;
    int  hist [4096];
    int  nsamp = 0, phase = 0;
    int  ucoef [32];
    bit  m_dec4 = 0, m_user = 0;
    int  npulse = 0, nexp = 0;
    bit  done = 0;
    logic [15:0] lf = 16'hACE1;

    always @(negedge clk) if (rst_n && out_valid) npulse++;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Direct-form model of R2, R5 and R9 over all 63 taps
    function automatic longint model_y();
        longint acc = 0;
        for (int j = 0; j < 63; j++) begin
            int m = nsamp - 1 - j;
            int k = (j <= 31) ? j : 62 - j;
            longint c = (m_user || m_dec4) ? longint'(ucoef[k]) : longint'(256 * (k + 1));
            if (m >= 0) acc += c * longint'(hist[m]);
        end
        acc = (acc + 16384) >>> 15;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return acc;
    endfunction

    function automatic int next_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return int'($signed(lf));
    endfunction

    task automatic wr_coef(input int addr, input int val);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = 5'(addr); coef_data = 16'(val);
        @(posedge clk); #1;
        coef_we = 1'b0;
        ucoef[addr] = val;
    endtask

    task automatic set_mode(input bit d4, input bit usr);
        @(negedge clk);
        mode_we = 1'b1; mode_dec4 = d4; mode_user = usr;
        @(posedge clk); #1;
        mode_we = 1'b0;
        m_dec4 = d4; m_user = usr; phase = 0;
    endtask

    // Feeds one sample; on a triggering sample, checks the R8 timing and the value
    task automatic send(input int x, input string tag, input bit poke);
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'(x);
        @(posedge clk); #1;
        in_valid = 1'b0;
        hist[nsamp] = x; nsamp++;
        phase++;
        if (phase == (m_dec4 ? 4 : 2)) begin
            longint exp_y;
            phase = 0;
            exp_y = model_y();
            nexp++;
            if (poke) begin
                repeat (10) @(posedge clk);
                @(negedge clk);
                coef_we = 1'b1; coef_addr = 5'd3; coef_data = 16'sd12345;
                mode_we = 1'b1; mode_dec4 = ~m_dec4; mode_user = ~m_user;
                @(posedge clk); #1;
                coef_we = 1'b0; mode_we = 1'b0;
                repeat (20) @(posedge clk);
            end else begin
                repeat (31) @(posedge clk);
            end
            @(negedge clk);
            check("R8 no early pulse", out_valid, 0);
            @(posedge clk);
            @(negedge clk);
            check("R8 pulse at edge 32", out_valid, 1);
            check(tag, out_data, exp_y);
            @(posedge clk);
            @(negedge clk);
            check("R8 single-cycle pulse", out_valid, 0);
        end else begin
            repeat (16) @(posedge clk);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        nsamp = 0; phase = 0; m_dec4 = 0; m_user = 0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R6: load the user bank while reset is held
        repeat (2) @(posedge clk);
        for (int k = 0; k < 32; k++) wr_coef(k, ((k * 1237) % 8000) - 4000);
        @(negedge clk);
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 out_data in reset", out_data, 0);
        rst_n = 1'b1;

        // R1 R5 R2 R3: built-in set, factor 2, impulses then a ramp
        send(16384, "R5 builtin impulse", 0);
        for (int i = 0; i < 66; i++) send(0, "R5 builtin impulse tail", 0);
        send(20000, "R2 odd-phase impulse", 0);
        for (int i = 0; i < 65; i++) send(0, "R2 odd-phase tail", 0);
        for (int i = 0; i < 40; i++) send(i * 700 - 14000, "R3 builtin ramp", 0);

        // R6: bank written during reset now in use
        set_mode(0, 1);
        for (int i = 0; i < 70; i++) send(next_lf(), "R6 user bank data", 0);

        // R4: factor 4 with the set-select bit low still uses the user bank
        set_mode(1, 0);
        for (int i = 0; i < 72; i++) send(next_lf(), "R4 dec4 forced user", 0);

        // R7 R10: writes during a computation must be dropped
        for (int i = 0; i < 4; i++) send(next_lf(), "R7 poke trigger", i == 3);
        for (int i = 0; i < 40; i++) send(next_lf(), "R7 R10 after busy writes", 0);

        // R6: an idle write takes effect
        wr_coef(3, -9000);
        for (int i = 0; i < 40; i++) send(next_lf(), "R6 idle write", 0);

        // R9: rounding with only the centre word set to 1
        set_mode(0, 1);
        for (int k = 0; k < 32; k++) wr_coef(k, (k == 31) ? 1 : 0);
        for (int i = 0; i < 96; i++) begin
            int v;
            case (i % 6)
                0: v = 16384;  1: v = 16383;  2: v = -16384;
                3: v = -16385; 4: v = 49151 - 65536; default: v = 0;
            endcase
            send(v, "R9 rounding", 0);
        end

        // R9: saturation both ways
        for (int k = 0; k < 32; k++) wr_coef(k, 32767);
        for (int i = 0; i < 66; i++) send(32767, "R9 positive clip", 0);
        check("R9 positive clip value", out_data, 32767);
        for (int i = 0; i < 66; i++) send(-32768, "R9 negative clip", 0);
        check("R9 negative clip value", out_data, -32768);

        // R1 R10: reset mid-run clears history and restores factor 2 / built-in set
        apply_reset();
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 out_valid after reset", out_valid, 0);
        send(1000, "R1 cleared history", 0);
        send(-3000, "R1 cleared history", 0);
        for (int i = 0; i < 20; i++) send(next_lf(), "R10 reset mode", 0);

        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R3 R4 total pulses", npulse, nexp);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule